// File: doc/BRIEF.md
# Split-Compare 8-bit PWM Timer

This block produces one pulse-width-modulated output from an 8-bit up-counter. A 16-bit compare word holds two separate 8-bit fields. The low byte sets where the counter wraps, so it fixes the period. The high byte sets how many counter ticks the output stays high after each wrap to zero. The output rises when the count is at zero and falls when the count reaches the high byte.

Software configures the block through a simple write port. One strobe loads four things at once: the run enable, the clock-halving select, the pin enable and the compare word. A separate strobe zeroes the count. To change settings safely, software first disables the timer and writes the new compare word. It then clears the count and enables the timer again. The block behaves in a defined way at every step of that sequence.

Top module: `pwm8_split_timer`

## Requirements
- R1: The count runs from zero up to the compare low byte (`cfg_cmp[7:0]`), then returns to zero on the next tick, so the period is low byte plus one ticks.
- R2: The output is high while the count is below the compare high byte (`cfg_cmp[15:8]`). It is set at count zero and cleared when the count equals the high byte, so it is high for high-byte ticks of each period.
- R3: A high byte greater than the low byte keeps the output high for the whole period. A high byte of zero keeps it low.
- R4: With `cfg_div2` = 0 the count advances on every clock. With `cfg_div2` = 1 it advances on every second clock, so each tick lasts two clocks. The first advance after enabling comes on the second clock.
- R5: With `cfg_out_en` = 0 the pin reads 0 while the count keeps running. Setting the bit again shows the waveform in step with the running count.
- R6: With `cfg_enable` = 0 the count holds its value and the pin reads 0. On re-enable, counting resumes from the held value.
- R7: `cnt_clr` forces the count to zero at the next clock edge and restarts the clock-halving phase, whatever the enable state. Together with a write while disabled, this gives the safe update sequence.
- R8: After synchronous reset the timer is disabled, the compare word is zero and the pin reads 0.
- R9: A compare word of 0x80FF gives a 256-tick period with 128 ticks high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Loads the four configuration fields below |
| cfg_enable | input | 1 | Run enable |
| cfg_div2 | input | 1 | 1 = count on every second clock |
| cfg_out_en | input | 1 | 1 = drive the waveform onto the pin |
| cfg_cmp | input | 16 | High byte = high time, low byte = period minus one |
| cnt_clr | input | 1 | Zero the count at the next edge |
| pwm_out | output | 1 | PWM pin |

## Verification
The bench sweeps every low byte from 0 to 15 against high bytes from 0 to 17, in both clock-select modes. A wrong wrap compare would stretch or shorten the period by a tick. A compare that used less-or-equal would add one high tick. A high byte above the period would wrongly drop the output before the wrap. It also checks two edge values: a zero period, where the output must be all high or all low, and the full-scale 0x80FF word. Pausing and masking are checked partway through a period. A design that kept running while disabled, or that reset the count on an output-enable change, would show a shifted waveform after the resume. A clear partway through the period must restart the pattern on the very next sample.

// File: rtl/pwm8_split_timer.sv
module pwm8_split_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic         cfg_enable,
  input  logic         cfg_div2,
  input  logic         cfg_out_en,
  input  logic [2*W-1:0] cfg_cmp,
  input  logic         cnt_clr,
  output logic         pwm_out
);

  localparam int CW = 2 * W;

  logic          en_q, div2_q, oe_q, phase_q;
  logic [CW-1:0] cmp_q;
  logic [W-1:0]  cnt_q;
  logic [W-1:0]  per, hi;
  logic          adv;

  assign per = cmp_q[W-1:0];
  assign hi  = cmp_q[CW-1:W];
  assign adv = en_q && (!div2_q || phase_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      div2_q  <= 1'b0;
      oe_q    <= 1'b0;
      cmp_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        en_q   <= cfg_enable;
        div2_q <= cfg_div2;
        oe_q   <= cfg_out_en;
        cmp_q  <= cfg_cmp;
      end
      if (cnt_clr) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (en_q) begin
        phase_q <= ~phase_q;
        if (adv) cnt_q <= (cnt_q == per) ? '0 : cnt_q + 1'b1;
      end else begin
        phase_q <= 1'b0;
      end
    end
  end

  assign pwm_out = en_q && oe_q && (cnt_q < hi);

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && !cnt_clr && cnt_q == per) |=> (cnt_q == '0));

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt_q == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !cnt_clr) |=> $stable(cnt_q));

  a_r4_halved: assert property (@(posedge clk) disable iff (rst)
    (adv && div2_q) |=> !(adv && div2_q));

  a_r3_full_high: assert property (@(posedge clk) disable iff (rst)
    (en_q && oe_q && hi > per && cnt_q <= per) |-> pwm_out);

  a_r5_masked: assert property (@(posedge clk) disable iff (rst)
    (!oe_q || !en_q) |-> !pwm_out);

endmodule

// File: tb/tb_pwm8_split_timer.sv
module tb_pwm8_split_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_enable = 1'b0, cfg_div2 = 1'b0, cfg_out_en = 1'b0;
  logic [15:0] cfg_cmp = '0;
  logic cnt_clr = 1'b0;
  logic pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm8_split_timer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .cfg_div2(cfg_div2), .cfg_out_en(cfg_out_en), .cfg_cmp(cfg_cmp),
    .cnt_clr(cnt_clr), .pwm_out(pwm_out)
  );

  function automatic logic model(int per, int hi, int t);
    return ((t % (per + 1)) < hi);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pwm_out=%0b expected %0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(logic en, logic d2, logic oe, logic [15:0] cmp, logic clr);
    cfg_we = 1'b1; cfg_enable = en; cfg_div2 = d2; cfg_out_en = oe;
    cfg_cmp = cmp; cnt_clr = clr;
    @(negedge clk);
    cfg_we = 1'b0; cnt_clr = 1'b0;
  endtask

  // safe update: disable + write + clear, then enable (R7)
  task automatic start(int per, int hi, logic d2);
    wr(1'b0, d2, 1'b1, {hi[7:0], per[7:0]}, 1'b1);
    wr(1'b1, d2, 1'b1, {hi[7:0], per[7:0]}, 1'b0);
  endtask

  task automatic sweep_one(int per, int hi, logic d2, int nsamp, string tag);
    int m;
    m = d2 ? 2 : 1;
    start(per, hi, d2);
    for (int k = 0; k < nsamp; k++) begin
      int t;
      string req;
      t = k / m;
      if (tag != "") req = tag;
      else if (hi > per || hi == 0) req = "R3";
      else if (d2) req = "R4";
      else if ((t % (per + 1)) == per) req = "R1";
      else req = "R2";
      check(req, pwm_out, model(per, hi, t));
      @(negedge clk);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R8", pwm_out, 1'b0);
      @(negedge clk);
    end
    // enabling with reset compare word (high byte 0) keeps pin low (R8)
    wr(1'b1, 1'b0, 1'b1, 16'h0000, 1'b0);
    wr(1'b1, 1'b0, 1'b1, 16'h0000, 1'b0);
    for (int k = 0; k < 4; k++) begin
      check("R8", pwm_out, 1'b0);
      @(negedge clk);
    end

    // near-exhaustive sweep of period and high time, both clock modes (R1 R2 R3 R4)
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 16; p++)
        for (int h = 0; h < 18; h++)
          sweep_one(p, h, d[0], 2 * (p + 1) * (d + 1), "");

    // full-scale half duty (R9)
    sweep_one(255, 128, 1'b0, 512, "R9");
    sweep_one(255, 128, 1'b1, 1024, "R9");

    // output-enable masking while counting continues (R5)
    start(9, 4, 1'b0);
    t = 0;
    for (int k = 0; k < 7; k++) begin check("R5", pwm_out, model(9, 4, t)); t++; @(negedge clk); end
    wr(1'b1, 1'b0, 1'b0, 16'h0409, 1'b0); t++;
    for (int k = 0; k < 13; k++) begin check("R5", pwm_out, 1'b0); t++; @(negedge clk); end
    wr(1'b1, 1'b0, 1'b1, 16'h0409, 1'b0); t++;
    for (int k = 0; k < 20; k++) begin check("R5", pwm_out, model(9, 4, t)); t++; @(negedge clk); end

    // disable holds the count, pin low, resume from held value (R6)
    start(11, 6, 1'b0);
    t = 0;
    for (int k = 0; k < 3; k++) begin check("R6", pwm_out, model(11, 6, t)); t++; @(negedge clk); end
    wr(1'b0, 1'b0, 1'b1, 16'h060B, 1'b0); t++;
    for (int k = 0; k < 9; k++) begin check("R6", pwm_out, 1'b0); @(negedge clk); end
    wr(1'b1, 1'b0, 1'b1, 16'h060B, 1'b0);
    for (int k = 0; k < 24; k++) begin check("R6", pwm_out, model(11, 6, t)); t++; @(negedge clk); end

    // clear mid-period restarts the pattern at zero (R7)
    start(7, 3, 1'b0);
    for (int k = 0; k < 6; k++) @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    for (int k = 0; k < 16; k++) begin check("R7", pwm_out, model(7, 3, k)); @(negedge clk); end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule